// File: doc/BRIEF.md
# Memory Access Domain and Permission Checker

This block decides whether a memory access that has already been translated may go ahead. Each access arrives with the descriptor's 4-bit domain number, its 2-bit access-permission code, the system-level protect (S) and read-only (R) control bits, the processor mode (supervisor or user) and the access direction (read or write). One cycle later the block reports whether the access is allowed. If it is not, the block reports whether a domain fault or a permission fault stopped it, and which domain was involved.

The check has two levels. A 32-bit domain access register, written by software, holds one 2-bit mode per domain. That mode can bypass the permission check entirely, deny the access outright, or hand the access on to the permission table. The permission table looks at the access-permission code, the S and R bits, the mode and the direction. A surrounding fault handler uses the registered fault code and domain to build its fault-status word.

Top module: `access_gate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `res_valid`, `res_allow`, `res_fault` and `res_fault_dom` are all zero. The domain access register resets to zero, so every access after reset gets a domain fault until the register is written.
- R2: An access presented with `acc_valid` high at a rising clock edge produces its result on the outputs right after that edge, and the result stays there for one cycle. After a cycle without `acc_valid`, `res_valid` and `res_allow` are 0, `res_fault` is 00 and `res_fault_dom` is 0.
- R3: The mode of domain n is bits [2n+1:2n] of the domain access register. A write with `dar_we` high takes effect at the clock edge, so an access in the same cycle as the write still uses the old value, and the next access uses the new one.
- R4: Domain mode 00 (no access) and mode 10 (reserved) deny every access with a domain fault, whatever the other inputs are.
- R5: Domain mode 11 (manager) allows every access. The permission code, S, R, mode and direction have no effect.
- R6: With domain mode 01 (client) and permission code 11, reads and writes are allowed in both supervisor and user mode.
- R7: With client mode and permission code 10, supervisor reads and writes are allowed, user reads are allowed, and a user write gets a permission fault.
- R8: With client mode and permission code 01, supervisor reads and writes are allowed. Every user access gets a permission fault.
- R9: With client mode and permission code 00, the S and R bits decide. With S=1 and R=0 only supervisor reads are allowed. With S=0 and R=1 reads are allowed in both modes. With S=R=0 or S=R=1 nothing is allowed. Any access that is not allowed gets a permission fault.
- R10: `res_fault` uses 00 for none, 01 for a domain fault and 10 for a permission fault. A domain fault takes priority over a permission fault. On a fault, `res_fault_dom` carries the access's domain number. On an allowed access, `res_fault_dom` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dar_we | input | 1 | Write strobe for the domain access register |
| dar_wdata | input | 32 | New value for the domain access register |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_domain | input | 4 | Domain number from the descriptor |
| acc_ap | input | 2 | Access-permission code from the descriptor |
| sys_s | input | 1 | System protect control bit |
| sys_r | input | 1 | Read-only control bit |
| acc_priv | input | 1 | 1 = supervisor mode, 0 = user mode |
| acc_write | input | 1 | 1 = write, 0 = read |
| res_valid | output | 1 | A result is present |
| res_allow | output | 1 | The access is allowed |
| res_fault | output | 2 | Fault code: 00 none, 01 domain, 10 permission |
| res_fault_dom | output | 4 | Domain of the faulting access, 0 otherwise |

## Verification
The only internal state is the domain access register, so a wrong bit in it shows up on the very next access to the affected domain. That access returns the wrong allow/fault decision one cycle after it is presented. A field read from the wrong bits, or a write that lands a cycle early, therefore shows up through accesses to domains with distinct modes. Such accesses include the reserved mode and an access in the same cycle as a write. Faults in the permission table show up only on client-mode accesses, so each permission code is exercised with both modes, both directions and every S/R combination.

// File: rtl/access_gate_pkg.sv
package access_gate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_DOMAIN = 2'b01,
    FLT_PERM   = 2'b10
  } fault_e;

  localparam logic [1:0] DM_NOACC  = 2'b00;
  localparam logic [1:0] DM_CLIENT = 2'b01;
  localparam logic [1:0] DM_RSVD   = 2'b10;
  localparam logic [1:0] DM_MGR    = 2'b11;
endpackage

// File: rtl/dar_store.sv
module dar_store #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/dom_field_sel.sv
module dom_field_sel #(
  parameter int NUM_DOMAINS = 16,
  parameter int FIELD_W     = 2,
  localparam int IDX_W      = $clog2(NUM_DOMAINS)
) (
  input  logic [NUM_DOMAINS*FIELD_W-1:0] dar,
  input  logic [IDX_W-1:0]               idx,
  output logic [FIELD_W-1:0]             field
);
  logic [FIELD_W-1:0] fields [NUM_DOMAINS];

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_split
    assign fields[g] = dar[g*FIELD_W +: FIELD_W];
  end

  assign field = fields[idx];
endmodule

// File: rtl/ap_rule_eval.sv
module ap_rule_eval (
  input  logic [1:0] ap,
  input  logic       sys_s,
  input  logic       sys_r,
  input  logic       priv,
  input  logic       wr,
  output logic       ok
);
  always_comb begin
    unique case (ap)
      2'b11: ok = 1'b1;
      2'b10: ok = priv | ~wr;
      2'b01: ok = priv;
      default: begin
        unique case ({sys_s, sys_r})
          2'b10:   ok = priv & ~wr;
          2'b01:   ok = ~wr;
          default: ok = 1'b0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/access_gate.sv
module access_gate
  import access_gate_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  parameter int FIELD_W     = 2,
  parameter int AP_W        = 2,
  localparam int DOM_W      = $clog2(NUM_DOMAINS),
  localparam int DAR_W      = NUM_DOMAINS * FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dar_we,
  input  logic [DAR_W-1:0] dar_wdata,
  input  logic             acc_valid,
  input  logic [DOM_W-1:0] acc_domain,
  input  logic [AP_W-1:0]  acc_ap,
  input  logic             sys_s,
  input  logic             sys_r,
  input  logic             acc_priv,
  input  logic             acc_write,
  output logic             res_valid,
  output logic             res_allow,
  output logic [1:0]       res_fault,
  output logic [DOM_W-1:0] res_fault_dom
);
  logic [DAR_W-1:0]   dar_q;
  logic [FIELD_W-1:0] dmode;
  logic               ap_ok;
  logic               nx_allow;
  fault_e             nx_fault;

  dar_store #(.WIDTH(DAR_W), .RESET_VAL('0)) u_dar (
    .clk(clk), .rst(rst), .we(dar_we), .wdata(dar_wdata), .q(dar_q)
  );

  dom_field_sel #(.NUM_DOMAINS(NUM_DOMAINS), .FIELD_W(FIELD_W)) u_sel (
    .dar(dar_q), .idx(acc_domain), .field(dmode)
  );

  ap_rule_eval u_ap (
    .ap(acc_ap), .sys_s(sys_s), .sys_r(sys_r),
    .priv(acc_priv), .wr(acc_write), .ok(ap_ok)
  );

  always_comb begin
    nx_allow = 1'b0;
    nx_fault = FLT_DOMAIN;
    if (dmode == DM_MGR) begin
      nx_allow = 1'b1;
      nx_fault = FLT_NONE;
    end else if (dmode == DM_CLIENT) begin
      nx_allow = ap_ok;
      nx_fault = ap_ok ? FLT_NONE : FLT_PERM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      res_valid     <= 1'b0;
      res_allow     <= 1'b0;
      res_fault     <= FLT_NONE;
      res_fault_dom <= '0;
    end else begin
      res_valid     <= 1'b1;
      res_allow     <= nx_allow;
      res_fault     <= nx_fault;
      res_fault_dom <= nx_allow ? '0 : acc_domain;
    end
  end
endmodule

// File: rtl/access_gate_sva.sv
module access_gate_sva #(
  parameter int NUM_DOMAINS = 16,
  localparam int DOM_W      = $clog2(NUM_DOMAINS),
  localparam int DAR_W      = NUM_DOMAINS * 2
) (
  input logic             clk,
  input logic             rst,
  input logic [DAR_W-1:0] dar,
  input logic             acc_valid,
  input logic [DOM_W-1:0] acc_domain,
  input logic [1:0]       acc_ap,
  input logic             res_valid,
  input logic             res_allow,
  input logic [1:0]       res_fault,
  input logic [DOM_W-1:0] res_fault_dom
);
  logic [1:0] cur_mode;
  assign cur_mode = dar[2*acc_domain +: 2];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_allow && res_fault == 2'b00 && res_fault_dom == '0)); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_allow ^ (res_fault != 2'b00)) && res_fault != 2'b11); // R10

  AST_DENY_MODE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && !$past(cur_mode[0])) |-> (res_fault == 2'b01)); // R4

  AST_MGR_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && $past(cur_mode) == 2'b11) |-> res_allow); // R5

  AST_FULL_AP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && $past(cur_mode) == 2'b01 && $past(acc_ap) == 2'b11)
      |-> res_allow); // R6

  AST_FAULT_DOM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && res_fault != 2'b00) |-> res_fault_dom == $past(acc_domain)); // R10
endmodule

bind access_gate access_gate_sva #(.NUM_DOMAINS(NUM_DOMAINS)) u_sva (
  .clk(clk), .rst(rst), .dar(dar_q), .acc_valid(acc_valid),
  .acc_domain(acc_domain), .acc_ap(acc_ap), .res_valid(res_valid),
  .res_allow(res_allow), .res_fault(res_fault), .res_fault_dom(res_fault_dom)
);

// File: tb/tb_access_gate.sv
module tb_access_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dar_we = 1'b0;
  logic [31:0] dar_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_domain = '0;
  logic [1:0]  acc_ap = '0;
  logic        sys_s = 1'b0, sys_r = 1'b0, acc_priv = 1'b0, acc_write = 1'b0;
  logic        res_valid, res_allow;
  logic [1:0]  res_fault;
  logic [3:0]  res_fault_dom;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] DAR_A = 32'hFFFF_BDCF;

  always #10 clk = ~clk;

  access_gate dut (
    .clk(clk), .rst(rst), .dar_we(dar_we), .dar_wdata(dar_wdata),
    .acc_valid(acc_valid), .acc_domain(acc_domain), .acc_ap(acc_ap),
    .sys_s(sys_s), .sys_r(sys_r), .acc_priv(acc_priv), .acc_write(acc_write),
    .res_valid(res_valid), .res_allow(res_allow), .res_fault(res_fault),
    .res_fault_dom(res_fault_dom)
  );

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {res_valid, res_allow, res_fault, res_fault_dom};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got v/a/f/d=%b expected %b", req, act, exp);
    end
  endtask

  // result expected: allowed -> code 00 dom 0; fault -> code and domain
  function automatic logic [7:0] want(input logic ok, input logic [1:0] code, input logic [3:0] d);
    return ok ? 8'b1100_0000 : {2'b10, code, d};
  endfunction

  task automatic access(input string req, input logic [3:0] d, input logic [1:0] ap,
                        input logic s, input logic r, input logic pv, input logic wr,
                        input logic ok, input logic [1:0] code);
    @(negedge clk);
    acc_valid = 1'b1; acc_domain = d; acc_ap = ap;
    sys_s = s; sys_r = r; acc_priv = pv; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, want(ok, code, d));
  endtask

  task automatic write_dar(input logic [31:0] v);
    @(negedge clk);
    dar_we = 1'b1; dar_wdata = v;
    @(negedge clk);
    dar_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset outputs", 8'h00);
    access("R1 reset deny", 4'd3, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01);
    @(negedge clk);
    check("R2 idle after result", 8'h00);
  endtask

  task automatic t_domain_modes();
    write_dar(DAR_A);
    access("R5 mgr dom0 ap00 user wr", 4'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    access("R5 mgr dom6 ap01 user rd", 4'd6, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
    access("R4 noacc dom2", 4'd2, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01);
    access("R4 reserved dom7", 4'd7, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01);
    access("R10 dom fault beats perm", 4'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01);
    access("R3 field 4 is client", 4'd4, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
  endtask

  task automatic t_ap_full_and_10();
    access("R6 ap11 user wr", 4'd4, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    access("R6 ap11 sup rd",  4'd4, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00);
    access("R7 ap10 user rd", 4'd4, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
    access("R7 ap10 user wr", 4'd4, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10);
    access("R7 ap10 sup wr",  4'd4, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00);
  endtask

  task automatic t_ap_01();
    access("R8 ap01 sup wr",  4'd4, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00);
    access("R8 ap01 sup rd",  4'd4, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00);
    access("R8 ap01 user wr", 4'd4, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10);
  endtask

  task automatic t_ap_00();
    access("R9 S1R0 sup rd",  4'd4, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00);
    access("R9 S1R0 sup wr",  4'd4, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10);
    access("R9 S1R0 user rd", 4'd4, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
    access("R9 S0R1 user rd", 4'd4, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00);
    access("R9 S0R1 sup wr",  4'd4, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10);
    access("R9 S0R0 sup rd",  4'd4, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10);
    access("R9 S1R1 sup rd",  4'd4, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10);
  endtask

  task automatic t_write_timing();
    // field 2 (bits 5:4) goes from 00 to 11; access in the write cycle sees 00
    @(negedge clk);
    dar_we = 1'b1; dar_wdata = DAR_A | 32'h30;
    acc_valid = 1'b1; acc_domain = 4'd2; acc_ap = 2'b00;
    sys_s = 1'b0; sys_r = 1'b0; acc_priv = 1'b0; acc_write = 1'b1;
    @(negedge clk);
    dar_we = 1'b0; acc_valid = 1'b0;
    check("R3 same-cycle write uses old", want(1'b0, 2'b01, 4'd2));
    access("R3 next access uses new", 4'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    access("R3 high field 15 mgr", 4'd15, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    write_dar(32'h4000_0000);
    access("R3 field 15 client", 4'd15, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10);
    access("R4 field 14 zero", 4'd14, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_domain_modes();
    t_ap_full_and_10();
    t_ap_01();
    t_ap_00();
    t_write_timing();
    @(negedge clk);
    check("R2 idle quiet", 8'h00);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule